// File: doc/BRIEF.md
# Multiplexed Asynchronous Pseudo-SRAM Controller

This block lets a synchronous host reach an asynchronous pseudo-static RAM of 2M words by 16 bits. The RAM shares its sixteen low address pins with its data pins and has five more pins for the high address bits. The host side is a plain request port. The host presents a request with a valid strobe, a read/write flag, a 21-bit word address, 16-bit write data and two active-high byte enables. The request is taken in the cycle where valid and ready are both high. Exactly one done pulse answers it, and a read returns its word on the read-data port together with that pulse.

Each access runs in two phases. In the first phase the controller selects the chip and pulls the address strobe low. It places the low address bits on the shared bus and the high bits on their own pins, and the RAM latches the address when the strobe returns high. In the second phase the bus turns around. For a read the controller releases the bus and then opens the RAM's output. For a write it drives the data and pulses write enable. Every timing limit is a picosecond parameter that is turned into a whole number of clock cycles, rounded up, from the clock-period parameter. After reset the chip stays deselected for the whole power-up interval.

Top module: `psram_mux_ctrl`

## Requirements
- R1: After reset, `mem_cs_n` stays high and `req_ready` stays low for at least 150 µs. `req_ready` then rises within a few cycles.
- R2: An accepted request is followed in the next cycle by `mem_cs_n` and `mem_adv_n` low. The address is bits [15:0] on the bus with `mem_dq_oe` high and bits [20:16] on `mem_a_hi`. The strobe stays low at least 5 ns. Select goes low at least 7 ns before the strobe rises. The address stays driven at least 2 ns after the rise.
- R3: On a read, `mem_dq_oe` is low for at least one cycle before `mem_oe_n` falls and stays low while `mem_oe_n` is low. `mem_oe_n` falls at least 5 ns after the strobe rises. Data is sampled no sooner than 70 ns after the strobe rise. The select-to-deselect span from the strobe fall is at least 80 ns. The sampled word appears on `rsp_rdata` with `rsp_done`.
- R4: On a write, `mem_we_n` falls at least 5 ns after the strobe rise and stays low at least 55 ns. The write data is stable on the driven bus at least 20 ns before `mem_we_n` rises.
- R5: `mem_we_n` is never low for more than 2.5 µs at a stretch.
- R6: Between accesses, `mem_cs_n` stays high at least 5 ns. `mem_oe_n` is high at least 8 ns before the next strobe fall. The bus is not driven until 8 ns after `mem_oe_n` rises.
- R7: During an access `{mem_ub_n, mem_lb_n}` equals the inverse of `req_be` (bit 1 = upper byte [15:8], bit 0 = lower byte [7:0]). A write changes only the enabled bytes, which a later read shows.
- R8: While `mem_cs_n` is high, the strobe, `mem_oe_n` and `mem_we_n` are high and the bus is released.
- R9: `req_ready` is low while a request is in flight. `rsp_done` lasts one cycle, and each accepted request gets exactly one done.
- R10: During reset `mem_cs_n` is high, `mem_dq_oe`, `req_ready` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_adv_n | output | 1 | Address strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_a_hi | output | 5 | Address bits [20:16] |
| mem_dq_out | output | 16 | Value driven on the shared bus |
| mem_dq_oe | output | 1 | Drive enable for the shared bus |
| mem_dq_in | input | 16 | Value read from the shared bus |

## Verification
The bench's RAM model returns a poison word until 70 ns after the strobe rise. A read sampled one cycle early therefore shows up as a data mismatch and not only as a timing note. Full-word writes at address zero and at the top address check the split of the address across the two pin groups. A lower-only write followed by an upper-only write to the same word, then full and single-lane reads, separates byte-lane masking from whole-word behaviour. Back-to-back requests with alternating bit patterns check the gaps between accesses and bus turnaround, and they would expose stale data left on the bus.

// File: rtl/psram_mux_ctrl.sv
module psram_mux_ctrl #(
  parameter int AW           = 21,
  parameter int DW           = 16,
  parameter int CLK_PS       = 4000,
  parameter int T_ADVLO_PS   = 5000,
  parameter int T_ASETUP_PS  = 5000,
  parameter int T_CSADV_PS   = 7000,
  parameter int T_AHOLD_PS   = 2000,
  parameter int T_ADVCMD_PS  = 5000,
  parameter int T_ACC_PS     = 70000,
  parameter int T_OEACC_PS   = 20000,
  parameter int T_RCYC_PS    = 80000,
  parameter int T_WPULSE_PS  = 55000,
  parameter int T_DSETUP_PS  = 20000,
  parameter int T_WCYC_PS    = 70000,
  parameter int T_CSHI_PS    = 5000,
  parameter int T_OEADV_PS   = 8000,
  parameter int T_TURN_PS    = 8000,
  parameter int T_WEMAX_PS   = 2500000,
  parameter int T_PWRUP_PS   = 150000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-DW-1:0] mem_a_hi,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cdiv(input int t);
    int c;
    c = (t + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_ADDR  = cdiv(mx(mx(T_ADVLO_PS, T_ASETUP_PS), T_CSADV_PS));
  localparam int N_AHOLD = cdiv(T_AHOLD_PS);
  localparam int N_HOLD  = mx(N_AHOLD + 1, cdiv(T_ADVCMD_PS));
  localparam int N_RD    = mx(1, mx(mx(cdiv(T_ACC_PS) - N_HOLD, cdiv(T_OEACC_PS)),
                                    cdiv(T_RCYC_PS) - N_ADDR - N_HOLD));
  localparam int N_WR    = mx(1, mx(mx(cdiv(T_WPULSE_PS), cdiv(T_DSETUP_PS)),
                                    cdiv(T_WCYC_PS) - N_ADDR - N_HOLD));
  localparam int N_REC   = mx(mx(cdiv(T_CSHI_PS), cdiv(T_OEADV_PS)), cdiv(T_TURN_PS));
  localparam int N_WEMAX = T_WEMAX_PS / CLK_PS;
  localparam int N_PWR   = cdiv(T_PWRUP_PS);
  localparam int CW      = $clog2(mx(N_PWR, N_WEMAX) + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_ADDR, S_HOLD, S_RD, S_WR, S_REC} st_t;

  st_t state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    be_q;

  logic          accept;
  logic          write_nx;
  logic [AW-1:0] addr_nx;
  logic [DW-1:0] wdata_nx;
  logic [1:0]    be_nx;
  logic          act_nx, sel_addr_nx, drive_nx;
  logic          rd_last, wr_last;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign write_nx  = accept ? req_write : wr_q;
  assign addr_nx   = accept ? req_addr  : addr_q;
  assign wdata_nx  = accept ? req_wdata : wdata_q;
  assign be_nx     = accept ? req_be    : be_q;
  assign rd_last   = (state == S_RD) && (cnt == CW'(N_RD - 1));
  assign wr_last   = (state == S_WR) && (cnt == CW'(N_WR - 1));

  always_comb begin
    state_nx = state;
    case (state)
      S_PWR:  if (cnt == CW'(N_PWR - 1))  state_nx = S_IDLE;
      S_IDLE: if (req_valid)              state_nx = S_ADDR;
      S_ADDR: if (cnt == CW'(N_ADDR - 1)) state_nx = S_HOLD;
      S_HOLD: if (cnt == CW'(N_HOLD - 1)) state_nx = wr_q ? S_WR : S_RD;
      S_RD:   if (rd_last)                state_nx = S_REC;
      S_WR:   if (wr_last)                state_nx = S_REC;
      S_REC:  if (cnt == CW'(N_REC - 1))  state_nx = S_IDLE;
      default:                            state_nx = S_IDLE;
    endcase
    cnt_nx = (state_nx != state) ? '0 : cnt + 1'b1;
  end

  always_comb begin
    act_nx      = state_nx inside {S_ADDR, S_HOLD, S_RD, S_WR};
    sel_addr_nx = (state_nx == S_ADDR) || (state_nx == S_HOLD && cnt_nx < CW'(N_AHOLD));
    drive_nx    = sel_addr_nx || (state_nx == S_WR) || (state_nx == S_HOLD && write_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_PWR;
      cnt     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      state   <= state_nx;
      cnt     <= cnt_nx;
      wr_q    <= write_nx;
      addr_q  <= addr_nx;
      wdata_q <= wdata_nx;
      be_q    <= be_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs_n   <= 1'b1;
      mem_adv_n  <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_a_hi   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      mem_cs_n   <= !act_nx;
      mem_adv_n  <= (state_nx != S_ADDR);
      mem_oe_n   <= (state_nx != S_RD);
      mem_we_n   <= (state_nx != S_WR);
      mem_ub_n   <= !(act_nx && be_nx[1]);
      mem_lb_n   <= !(act_nx && be_nx[0]);
      mem_a_hi   <= addr_nx[AW-1:DW];
      mem_dq_out <= sel_addr_nx ? addr_nx[DW-1:0] : wdata_nx;
      mem_dq_oe  <= drive_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= rd_last || wr_last;
      if (rd_last) rsp_rdata <= mem_dq_in;
    end
  end

  logic [CW-1:0] we_lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || mem_we_n) we_lo_cnt <= '0;
    else if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  AST_PWRUP_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWR) |-> mem_cs_n) else $error("select during power-up"); // R1
  AST_ACCEPT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_cs_n && !mem_adv_n && !req_ready)); // R2
  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe) else $error("bus driven while RAM output open"); // R3
  AST_WE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo_cnt <= CW'(N_WEMAX)) else $error("write enable low too long"); // R5
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_adv_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done) else $error("done longer than one cycle"); // R9

endmodule

// File: tb/psram_mux_ctrl_tb.sv
module psram_mux_ctrl_tb;

  localparam longint PWR_NS = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [4:0]  mem_a_hi;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hBEEF;

  always #2 clk = ~clk;

  psram_mux_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_a_hi(mem_a_hi),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct {
    bit          wr;
    logic [20:0] addr;
    logic [1:0]  be;
    logic [15:0] exp;
  } req_t;

  req_t q[$];
  logic [15:0] shadow [int];
  logic [15:0] ram [int];
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  longint t_rel = 0, t_adv_fall = 0, t_adv_rise = 0, t_cs_fall = 0, t_cs_rise = -100;
  longint t_oe_rise = -100, t_we_fall = 0, t_dchg = 0, t_ready = -1;
  bit p_cs_n = 1, p_adv_n = 1, p_oe_n = 1, p_we_n = 1, p_ub_n = 1, p_lb_n = 1;
  bit p_dq_oe = 0, p_done = 0, rd_cycle = 0;
  logic [15:0] p_dq_out = '0;
  logic [4:0]  p_a_hi = '0;
  int cap = 0;

  always @(negedge clk) begin
    longint now;
    now = $time;
    cycles++;
    if (rst_n) begin
      if (now - t_rel < PWR_NS)
        chk(mem_cs_n && !req_ready, "R1 power-up hold", {mem_cs_n, req_ready}, 2'b10);
      if (req_ready && t_ready < 0) begin
        t_ready = now;
        chk(now - t_rel >= PWR_NS && now - t_rel <= PWR_NS + 40, "R1 ready rise", now - t_rel, PWR_NS);
      end
      if (mem_cs_n)
        chk(!mem_dq_oe && mem_adv_n && mem_oe_n && mem_we_n, "R8 standby pins",
            {mem_dq_oe, mem_adv_n, mem_oe_n, mem_we_n}, 4'b0111);
      if (!mem_oe_n) chk(!mem_dq_oe, "R3 bus released during read", mem_dq_oe, 0);
      if (mem_dq_oe && !mem_cs_n && mem_oe_n)
        chk(now - t_oe_rise >= 8, "R6 turnaround", now - t_oe_rise, 8);
      if (q.size() > 0) begin
        chk(!req_ready, "R9 ready low in flight", req_ready, 0);
        if (!mem_cs_n) chk({mem_ub_n, mem_lb_n} == ~q[0].be, "R7 byte selects", {mem_ub_n, mem_lb_n}, ~q[0].be);
      end
      if (!mem_cs_n && p_cs_n) begin
        t_cs_fall = now;
        chk(now - t_cs_rise >= 5, "R6 select high gap", now - t_cs_rise, 5);
      end
      if (!mem_adv_n && p_adv_n) begin
        t_adv_fall = now;
        chk(mem_oe_n && now - t_oe_rise >= 8, "R6 output off before strobe", now - t_oe_rise, 8);
      end
      if (mem_adv_n && !p_adv_n) begin
        t_adv_rise = now;
        cap = int'({p_a_hi, p_dq_out});
        rd_cycle = (q.size() > 0) ? !q[0].wr : 1'b0;
        chk(now - t_adv_fall >= 5, "R2 strobe width", now - t_adv_fall, 5);
        chk(now - t_cs_fall >= 7, "R2 select before strobe rise", now - t_cs_fall, 7);
        chk(p_dq_oe && q.size() > 0 && cap == int'(q[0].addr), "R2 address on pins", cap,
            (q.size() > 0) ? q[0].addr : 0);
        chk(mem_dq_oe && mem_dq_out == p_dq_out && mem_a_hi == p_a_hi, "R2 address hold",
            {mem_a_hi, mem_dq_out}, {p_a_hi, p_dq_out});
      end
      if (!mem_oe_n && p_oe_n) begin
        chk(now - t_adv_rise >= 5, "R3 output after strobe", now - t_adv_rise, 5);
        chk(!p_dq_oe, "R3 bus freed before output", p_dq_oe, 0);
      end
      if (mem_oe_n && !p_oe_n) t_oe_rise = now;
      if (!mem_we_n && p_we_n) begin
        t_we_fall = now;
        chk(now - t_adv_rise >= 5, "R4 write after strobe", now - t_adv_rise, 5);
      end
      if (!mem_we_n) chk(now - t_we_fall <= 2500, "R5 write low cap", now - t_we_fall, 2500);
      if (mem_we_n && !p_we_n) begin
        logic [15:0] w;
        chk(now - t_we_fall >= 55, "R4 write pulse", now - t_we_fall, 55);
        chk(p_dq_oe && now - t_dchg >= 20, "R4 data setup", now - t_dchg, 20);
        w = ram.exists(cap) ? ram[cap] : 16'h0;
        if (!p_lb_n) w[7:0]  = p_dq_out[7:0];
        if (!p_ub_n) w[15:8] = p_dq_out[15:8];
        ram[cap] = w;
      end
      if (mem_cs_n && !p_cs_n) begin
        t_cs_rise = now;
        if (rd_cycle) chk(now - t_adv_fall >= 80, "R3 read cycle length", now - t_adv_fall, 80);
      end
      if (rsp_done) begin
        chk(q.size() > 0, "R9 done without request", q.size(), 1);
        if (q.size() > 0) begin
          req_t r;
          logic [15:0] m;
          r = q.pop_front();
          m = {{8{r.be[1]}}, {8{r.be[0]}}};
          if (!r.wr) chk((rsp_rdata & m) == (r.exp & m), "R3 R7 read data", rsp_rdata & m, r.exp & m);
        end
      end
      chk(!(rsp_done && p_done), "R9 done pulse width", {p_done, rsp_done}, 0);
      if ({mem_dq_oe, mem_dq_out} != {p_dq_oe, p_dq_out}) t_dchg = now;
      if (!mem_cs_n && !mem_oe_n)
        mem_dq_in <= (now - t_adv_rise + 4 >= 70) ? (ram.exists(cap) ? ram[cap] : 16'h0) : 16'hDEAD;
      else
        mem_dq_in <= 16'hBEEF;
    end
    p_cs_n = mem_cs_n; p_adv_n = mem_adv_n; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
    p_ub_n = mem_ub_n; p_lb_n = mem_lb_n; p_dq_oe = mem_dq_oe; p_dq_out = mem_dq_out;
    p_a_hi = mem_a_hi; p_done = rsp_done;
  end

  task automatic issue(input bit wr, input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    req_t r;
    logic [15:0] s;
    do @(negedge clk); while (!req_ready);
    #1;
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    r.wr = wr; r.addr = a; r.be = be; r.exp = s;
    if (wr) begin
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      shadow[int'(a)] = s;
    end
    q.push_back(r);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_dq_oe && !req_ready && !rsp_done, "R10 reset state",
        {mem_cs_n, mem_dq_oe, req_ready, rsp_done}, 4'b1000);
    #1 rst_n = 1'b1;
    t_rel = $time - 1;
    issue(1, 21'h000000, 16'hA5A5, 2'b11);
    issue(0, 21'h000000, 16'h0000, 2'b11);
    issue(1, 21'h1FFFFF, 16'h1234, 2'b11);
    issue(0, 21'h1FFFFF, 16'h0000, 2'b11);
    issue(1, 21'h00ABCD, 16'h00EE, 2'b01);
    issue(1, 21'h00ABCD, 16'h7700, 2'b10);
    issue(0, 21'h00ABCD, 16'h0000, 2'b11);
    issue(0, 21'h00ABCD, 16'h0000, 2'b01);
    issue(0, 21'h1FFFFF, 16'h0000, 2'b10);
    issue(1, 21'h015555, 16'h5555, 2'b11);
    issue(1, 21'h00AAAA, 16'hAAAA, 2'b11);
    issue(0, 21'h015555, 16'h0000, 2'b11);
    issue(0, 21'h00AAAA, 16'h0000, 2'b11);
    while (q.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(q.size() == 0 && req_ready, "R9 all requests done", q.size(), 0);
    finish_run();
  end

endmodule